// File: doc/BRIEF.md
# Drawing-Engine Configuration Register Slave

This block is the register bank through which a processor sets up a 2D drawing engine. It sits on a single-master, Wishbone-style bus with classic cycle, strobe and acknowledge handshaking. It stores every drawing parameter the engine needs, including the fill colour, the colour key and the alpha value. It also holds the source, destination and clip corner points, along with the base address and dimensions of the render target and of the texture. Every stored value is driven continuously onto a plain output, so the engine reads its settings directly.

The control word does two jobs. Its low bits are sticky mode settings: pixel depth, texture fetch, blending and colour keying. Two higher bits are commands. Writing the control word with the rectangle or line bit set fires a one-cycle start pulse towards the engine and marks the block busy. The command bits are never stored. When the engine reports completion, busy drops and an interrupt is raised. Software clears the interrupt by writing the status word.

Point and size words pack two 16-bit coordinates into one word: the first coordinate sits in bits 31:16 and the second in bits 15:0. For example, a 640 by 480 size is written as 0x028001E0.

Top module: `draw_cfg_slave`

## Requirements
- R1: An accepted access with all four byte selects high, an aligned address and a word index below 15 gets `ackOut` high for exactly one cycle, in the cycle after the request. `errOut` stays low for such an access. While `ackOut` or `errOut` is high, no new access is taken.
- R2: An access is rejected if any byte select is low, if address bits 1:0 are non-zero, or if the byte address is 0x3C or above. A rejected access gets `errOut` for one cycle instead of `ackOut`. It changes no register and starts no draw.
- R3: Byte offsets decode as follows. Colour is at 0x20, colour key at 0x38 and alpha at 0x34. The destination corners are at 0x10 and 0x14, the source corners at 0x08 and 0x0C, and the clip corners at 0x18 and 0x1C. Target base and size are at 0x24 and 0x28; texture base and size are at 0x2C and 0x30. A write stores the full word, which appears on its output port in the cycle after the request. A later read returns the same word.
- R4: Control word (offset 0x00) bits are laid out as follows. Bits 1:0 give the pixel depth (0 = 8-bit, 1 = 16-bit, 2 = 24-bit, 3 = 32-bit). Bit 2 enables texture reads, bit 3 enables blending and bit 4 enables colour keying. These five bits persist until the next control write. A read of the control word returns only these bits; all other bits read 0.
- R5: A control write with bit 8 set gives `rectStart` high for one cycle, in the same cycle as its ack. A control write with bit 9 set does the same on `lineStart`. If both bits are set, only `rectStart` fires.
- R6: `busyOut` rises in the cycle of a start pulse and stays high until a completion is taken.
- R7: A draw request written while `busyOut` is high produces no start pulse. The mode bits in that same write are still stored.
- R8: `doneIn` high while busy clears `busyOut` and sets `irqOut` in the next cycle. `doneIn` while idle has no effect.
- R9: A write to the status word (offset 0x04) with bit 1 set clears `irqOut` in the next cycle. A completion in the same cycle wins over the clear. Writes to the status word change nothing else.
- R10: A read of the status word returns busy in bit 0 and the interrupt flag in bit 1. All other bits read 0.
- R11: A synchronous `rst` clears every stored word, the mode bits, busy, the interrupt, ack, error and the start pulses.
- R12: `datOut` is zero in every cycle except the ack cycle of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cycIn | input | 1 | Bus cycle valid |
| stbIn | input | 1 | Bus strobe |
| weIn | input | 1 | 1 = write, 0 = read |
| adrIn | input | ADDR_W | Byte address inside the window |
| selIn | input | 4 | Byte selects, all four required |
| datIn | input | 32 | Write data |
| ackOut | output | 1 | Access accepted, one cycle |
| errOut | output | 1 | Access rejected, one cycle |
| datOut | output | 32 | Read data, valid with ack |
| doneIn | input | 1 | Drawing engine finished |
| rectStart | output | 1 | Rectangle start pulse |
| lineStart | output | 1 | Line start pulse |
| busyOut | output | 1 | Draw in progress |
| irqOut | output | 1 | Draw-complete interrupt |
| colorDepth | output | 2 | Pixel depth selection |
| texReadEn | output | 1 | Texture fetch enable |
| blendEn | output | 1 | Blending enable |
| keyEn | output | 1 | Colour-key enable |
| srcPt0 | output | 32 | Source corner 0 |
| srcPt1 | output | 32 | Source corner 1 |
| dstPt0 | output | 32 | Destination corner 0 |
| dstPt1 | output | 32 | Destination corner 1 |
| clipPt0 | output | 32 | Clip corner 0 |
| clipPt1 | output | 32 | Clip corner 1 |
| drawColor | output | 32 | Fill colour |
| targetBase | output | 32 | Render target base address |
| targetSize | output | 32 | Render target width/height |
| texBase | output | 32 | Texture base address |
| texSize | output | 32 | Texture width/height |
| alphaVal | output | 32 | Global alpha |
| keyColor | output | 32 | Colour-key value |

## Verification
The bench builds the block with its default `ADDR_W` of 8. Byte addresses then run up to 0xFF, so the unused words from 0x3C to 0xFC are reachable and can be shown to raise an error. Misaligned and partial-select accesses are reachable at the same setting. A behavioural model tracks every output each clock. Directed sequences cover the following cases:
- a draw request arriving while busy;
- completion arriving while idle;
- completion coinciding with an interrupt clear;
- both command bits set at once;
- a reset taken mid-draw.

// File: rtl/draw_cfg_pkg.sv
package draw_cfg_pkg;
  localparam int REG_WORDS   = 15;
  localparam int FIRST_PLAIN = 2;
  localparam int MODE_W      = 5;
  localparam int BIT_RECT    = 8;
  localparam int BIT_LINE    = 9;
  localparam int BIT_IRQCLR  = 1;

  localparam logic [3:0] IDX_CTRL   = 4'd0;
  localparam logic [3:0] IDX_STAT   = 4'd1;
  localparam logic [3:0] IDX_SRC0   = 4'd2;
  localparam logic [3:0] IDX_SRC1   = 4'd3;
  localparam logic [3:0] IDX_DST0   = 4'd4;
  localparam logic [3:0] IDX_DST1   = 4'd5;
  localparam logic [3:0] IDX_CLIP0  = 4'd6;
  localparam logic [3:0] IDX_CLIP1  = 4'd7;
  localparam logic [3:0] IDX_COLOR  = 4'd8;
  localparam logic [3:0] IDX_TBASE  = 4'd9;
  localparam logic [3:0] IDX_TSIZE  = 4'd10;
  localparam logic [3:0] IDX_XBASE  = 4'd11;
  localparam logic [3:0] IDX_XSIZE  = 4'd12;
  localparam logic [3:0] IDX_ALPHA  = 4'd13;
  localparam logic [3:0] IDX_KEY    = 4'd14;

  // strobes from bus control to the register datapath
  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [3:0]  idx;
    logic [31:0] wdata;
  } regStrobe_t;
endpackage

// File: rtl/draw_cfg_ctrl.sv
module draw_cfg_ctrl
  import draw_cfg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cycIn,
  input  logic              stbIn,
  input  logic              weIn,
  input  logic [ADDR_W-1:0] adrIn,
  input  logic [3:0]        selIn,
  input  logic [31:0]       datIn,
  input  logic [31:0]       rdWord,
  output regStrobe_t        strobe,
  output logic              ackOut,
  output logic              errOut,
  output logic [31:0]       datOut
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic take, inWindow, aligned, fullWord, good;

  always_comb begin
    wordIdx  = adrIn[ADDR_W-1:2];
    take     = cycIn && stbIn && !ackOut && !errOut;
    inWindow = wordIdx < IDX_W'(REG_WORDS);
    aligned  = (adrIn[1:0] == 2'b00);
    fullWord = &selIn;
    good     = inWindow && aligned && fullWord;
    strobe.wr    = take && good && weIn;
    strobe.rd    = take && good && !weIn;
    strobe.idx   = wordIdx[3:0];
    strobe.wdata = datIn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ackOut <= 1'b0;
      errOut <= 1'b0;
      datOut <= '0;
    end else begin
      ackOut <= take && good;
      errOut <= take && !good;
      datOut <= strobe.rd ? rdWord : '0;
    end
  end
endmodule

// File: rtl/draw_cfg_data.sv
module draw_cfg_data
  import draw_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  regStrobe_t        strobe,
  input  logic              doneIn,
  output logic [31:0]       rdWord,
  output logic              busyOut,
  output logic              irqOut,
  output logic              rectStart,
  output logic              lineStart,
  output logic [MODE_W-1:0] modeBits,
  output logic [31:0]       plainRegs [FIRST_PLAIN:REG_WORDS-1]
);
  logic ctrlWr, statWr, rectReq, lineReq, finish;

  always_comb begin
    ctrlWr  = strobe.wr && (strobe.idx == IDX_CTRL);
    statWr  = strobe.wr && (strobe.idx == IDX_STAT);
    rectReq = ctrlWr && strobe.wdata[BIT_RECT] && !busyOut;
    lineReq = ctrlWr && strobe.wdata[BIT_LINE] && !strobe.wdata[BIT_RECT] && !busyOut;
    finish  = doneIn && busyOut;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = FIRST_PLAIN; i < REG_WORDS; i++) plainRegs[i] <= '0;
    end else begin
      for (int i = FIRST_PLAIN; i < REG_WORDS; i++)
        if (strobe.wr && strobe.idx == 4'(i)) plainRegs[i] <= strobe.wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeBits  <= '0;
      rectStart <= 1'b0;
      lineStart <= 1'b0;
      busyOut   <= 1'b0;
      irqOut    <= 1'b0;
    end else begin
      if (ctrlWr) modeBits <= strobe.wdata[MODE_W-1:0];
      rectStart <= rectReq;
      lineStart <= lineReq;
      if (rectReq || lineReq) busyOut <= 1'b1;
      else if (finish)        busyOut <= 1'b0;
      if (finish)                                irqOut <= 1'b1;
      else if (statWr && strobe.wdata[BIT_IRQCLR]) irqOut <= 1'b0;
    end
  end

  always_comb begin
    rdWord = '0;
    if (strobe.idx == IDX_CTRL)      rdWord = {{(32-MODE_W){1'b0}}, modeBits};
    else if (strobe.idx == IDX_STAT) rdWord = {30'd0, irqOut, busyOut};
    else
      for (int i = FIRST_PLAIN; i < REG_WORDS; i++)
        if (strobe.idx == 4'(i)) rdWord = plainRegs[i];
  end
endmodule

// File: rtl/draw_cfg_slave.sv
module draw_cfg_slave
  import draw_cfg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cycIn,
  input  logic              stbIn,
  input  logic              weIn,
  input  logic [ADDR_W-1:0] adrIn,
  input  logic [3:0]        selIn,
  input  logic [31:0]       datIn,
  output logic              ackOut,
  output logic              errOut,
  output logic [31:0]       datOut,
  input  logic              doneIn,
  output logic              rectStart,
  output logic              lineStart,
  output logic              busyOut,
  output logic              irqOut,
  output logic [1:0]        colorDepth,
  output logic              texReadEn,
  output logic              blendEn,
  output logic              keyEn,
  output logic [31:0]       srcPt0,
  output logic [31:0]       srcPt1,
  output logic [31:0]       dstPt0,
  output logic [31:0]       dstPt1,
  output logic [31:0]       clipPt0,
  output logic [31:0]       clipPt1,
  output logic [31:0]       drawColor,
  output logic [31:0]       targetBase,
  output logic [31:0]       targetSize,
  output logic [31:0]       texBase,
  output logic [31:0]       texSize,
  output logic [31:0]       alphaVal,
  output logic [31:0]       keyColor
);
  regStrobe_t        strobe;
  logic [31:0]       rdWord;
  logic [MODE_W-1:0] modeBits;
  logic [31:0]       plainRegs [FIRST_PLAIN:REG_WORDS-1];

  draw_cfg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .cycIn(cycIn), .stbIn(stbIn), .weIn(weIn),
    .adrIn(adrIn), .selIn(selIn), .datIn(datIn), .rdWord(rdWord),
    .strobe(strobe), .ackOut(ackOut), .errOut(errOut), .datOut(datOut)
  );

  draw_cfg_data u_data (
    .clk(clk), .rst(rst), .strobe(strobe), .doneIn(doneIn),
    .rdWord(rdWord), .busyOut(busyOut), .irqOut(irqOut),
    .rectStart(rectStart), .lineStart(lineStart),
    .modeBits(modeBits), .plainRegs(plainRegs)
  );

  assign colorDepth = modeBits[1:0];
  assign texReadEn  = modeBits[2];
  assign blendEn    = modeBits[3];
  assign keyEn      = modeBits[4];
  assign srcPt0     = plainRegs[IDX_SRC0];
  assign srcPt1     = plainRegs[IDX_SRC1];
  assign dstPt0     = plainRegs[IDX_DST0];
  assign dstPt1     = plainRegs[IDX_DST1];
  assign clipPt0    = plainRegs[IDX_CLIP0];
  assign clipPt1    = plainRegs[IDX_CLIP1];
  assign drawColor  = plainRegs[IDX_COLOR];
  assign targetBase = plainRegs[IDX_TBASE];
  assign targetSize = plainRegs[IDX_TSIZE];
  assign texBase    = plainRegs[IDX_XBASE];
  assign texSize    = plainRegs[IDX_XSIZE];
  assign alphaVal   = plainRegs[IDX_ALPHA];
  assign keyColor   = plainRegs[IDX_KEY];
endmodule

// File: rtl/draw_cfg_chk.sv
module draw_cfg_chk (
  input logic        clk,
  input logic        rst,
  input logic        ackOut,
  input logic        errOut,
  input logic [31:0] datOut,
  input logic        doneIn,
  input logic        rectStart,
  input logic        lineStart,
  input logic        busyOut,
  input logic        irqOut
);
  assert_ack_single_R1: assert property (@(posedge clk) disable iff (rst)
    ackOut |=> !ackOut);
  assert_ack_err_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(ackOut && errOut));
  assert_err_no_data_R12: assert property (@(posedge clk) disable iff (rst)
    errOut |-> (datOut == 32'd0));
  assert_start_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(rectStart && lineStart));
  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    (rectStart || lineStart) |=> !(rectStart || lineStart));
  assert_start_with_ack_R5: assert property (@(posedge clk) disable iff (rst)
    (rectStart || lineStart) |-> ackOut);
  assert_busy_with_start_R6: assert property (@(posedge clk) disable iff (rst)
    (rectStart || lineStart) |-> busyOut);
  assert_busy_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busyOut) |-> (rectStart || lineStart));
  assert_no_start_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (rectStart || lineStart) |-> !$past(busyOut));
  assert_done_R8: assert property (@(posedge clk) disable iff (rst)
    (doneIn && busyOut) |=> (!busyOut && irqOut));
  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irqOut) |-> $past(doneIn && busyOut));
  assert_reset_R11: assert property (@(posedge clk)
    rst |=> (!busyOut && !irqOut && !ackOut && !errOut && !rectStart && !lineStart));
endmodule

bind draw_cfg_slave draw_cfg_chk u_chk (.*);

// File: tb/tb_draw_cfg_slave.sv
module tb_draw_cfg_slave;
  logic clk = 1'b0, rst = 1'b1;
  logic cycIn = 0, stbIn = 0, weIn = 0, doneIn = 0;
  logic [7:0] adrIn = '0;
  logic [3:0] selIn = '0;
  logic [31:0] datIn = '0;
  logic ackOut, errOut, rectStart, lineStart, busyOut, irqOut, texReadEn, blendEn, keyEn;
  logic [31:0] datOut;
  logic [1:0] colorDepth;
  logic [31:0] srcPt0, srcPt1, dstPt0, dstPt1, clipPt0, clipPt1, drawColor;
  logic [31:0] targetBase, targetSize, texBase, texSize, alphaVal, keyColor;

  int nChecks = 0, nErrors = 0;
  bit started = 0;

  draw_cfg_slave #(.ADDR_W(8)) dut (
    .clk(clk), .rst(rst), .cycIn(cycIn), .stbIn(stbIn), .weIn(weIn),
    .adrIn(adrIn), .selIn(selIn), .datIn(datIn), .ackOut(ackOut),
    .errOut(errOut), .datOut(datOut), .doneIn(doneIn), .rectStart(rectStart),
    .lineStart(lineStart), .busyOut(busyOut), .irqOut(irqOut),
    .colorDepth(colorDepth), .texReadEn(texReadEn), .blendEn(blendEn),
    .keyEn(keyEn), .srcPt0(srcPt0), .srcPt1(srcPt1), .dstPt0(dstPt0),
    .dstPt1(dstPt1), .clipPt0(clipPt0), .clipPt1(clipPt1),
    .drawColor(drawColor), .targetBase(targetBase), .targetSize(targetSize),
    .texBase(texBase), .texSize(texSize), .alphaVal(alphaVal), .keyColor(keyColor)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  logic [31:0] mReg [15];
  logic [4:0]  mMode;
  logic mBusy, mIrq, mRect, mLine, mAck, mErr;
  logic [31:0] mDat;

  always @(posedge clk) begin
    logic bad, acc, nRect, nLine, nAck, nErr, clr;
    logic [31:0] nDat;
    int idx;
    if (rst) begin
      for (int i = 0; i < 15; i++) mReg[i] = 0;
      mMode = 0; mBusy = 0; mIrq = 0; mRect = 0; mLine = 0;
      mAck = 0; mErr = 0; mDat = 0;
    end else begin
      idx = int'(adrIn) / 4;
      acc = cycIn && stbIn && !mAck && !mErr;
      bad = (selIn != 4'hF) || (adrIn % 4 != 0) || (idx >= 15);
      nAck = acc && !bad; nErr = acc && bad; nDat = 0;
      nRect = 0; nLine = 0; clr = 0;
      if (nAck && !weIn) begin
        if (idx == 0) nDat = {27'd0, mMode};
        else if (idx == 1) nDat = {30'd0, mIrq, mBusy};
        else nDat = mReg[idx];
      end
      if (nAck && weIn) begin
        if (idx == 0) begin
          mMode = datIn[4:0];
          if (!mBusy && datIn[8]) nRect = 1;
          else if (!mBusy && datIn[9]) nLine = 1;
        end else if (idx == 1) clr = datIn[1];
        else mReg[idx] = datIn;
      end
      if (doneIn && mBusy) begin mIrq = 1; mBusy = 0; end
      else if (clr) mIrq = 0;
      if (nRect || nLine) mBusy = 1;
      mRect = nRect; mLine = nLine; mAck = nAck; mErr = nErr; mDat = nDat;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk("R1 ack", 32'(ackOut), 32'(mAck));
    chk("R2 err", 32'(errOut), 32'(mErr));
    chk("R12 datOut", datOut, mDat);
    chk("R5 rectStart", 32'(rectStart), 32'(mRect));
    chk("R5 lineStart", 32'(lineStart), 32'(mLine));
    chk("R6 busy", 32'(busyOut), 32'(mBusy));
    chk("R8 irq", 32'(irqOut), 32'(mIrq));
    chk("R4 mode", {27'd0, keyEn, blendEn, texReadEn, colorDepth}, {27'd0, mMode});
    chk("R3 srcPt0", srcPt0, mReg[2]);     chk("R3 srcPt1", srcPt1, mReg[3]);
    chk("R3 dstPt0", dstPt0, mReg[4]);     chk("R3 dstPt1", dstPt1, mReg[5]);
    chk("R3 clipPt0", clipPt0, mReg[6]);   chk("R3 clipPt1", clipPt1, mReg[7]);
    chk("R3 drawColor", drawColor, mReg[8]);
    chk("R3 targetBase", targetBase, mReg[9]);
    chk("R3 targetSize", targetSize, mReg[10]);
    chk("R3 texBase", texBase, mReg[11]); chk("R3 texSize", texSize, mReg[12]);
    chk("R3 alphaVal", alphaVal, mReg[13]); chk("R3 keyColor", keyColor, mReg[14]);
  end

  logic [31:0] gotDat;
  logic gotAck, gotErr, gotRect, gotLine;

  task automatic acc(input logic we, input logic [7:0] a, input logic [31:0] d,
                     input logic [3:0] s, input logic dn);
    @(negedge clk);
    cycIn = 1; stbIn = 1; weIn = we; adrIn = a; datIn = d; selIn = s; doneIn = dn;
    @(negedge clk);
    cycIn = 0; stbIn = 0; doneIn = 0;
    gotDat = datOut; gotAck = ackOut; gotErr = errOut;
    gotRect = rectStart; gotLine = lineStart;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    acc(1, a, d, 4'hF, 0);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    acc(0, a, 32'h0, 4'hF, 0);
    chk(tag, gotDat, exp);
  endtask

  task automatic pulseDone;
    @(negedge clk); doneIn = 1;
    @(negedge clk); doneIn = 0;
  endtask

  initial begin
    #4000000;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; started = 1;
    // R11: reset state
    chk("R11 busy after reset", 32'(busyOut), 0);
    chk("R11 color after reset", drawColor, 0);
    // R3: plain registers
    wr(8'h20, 32'h12345671); chk("R1 write ack", 32'(gotAck), 1);
    rd(8'h20, 32'h12345671, "R3 color readback");
    wr(8'h28, 32'h028001E0);
    chk("R3 target width field", 32'(targetSize[31:16]), 640);
    rd(8'h28, 32'h028001E0, "R3 target size readback");
    wr(8'h08, 32'h00040004); wr(8'h0C, 32'h00080006); wr(8'h10, 32'h006E006E);
    wr(8'h14, 32'h00780073); wr(8'h18, 32'h0); wr(8'h1C, 32'h028001E0);
    wr(8'h24, 32'h00800000); wr(8'h2C, 32'h01F00000); wr(8'h30, 32'h000A000A);
    wr(8'h34, 32'h000000C0); wr(8'h38, 32'h0000F18F);
    rd(8'h38, 32'h0000F18F, "R3 key readback");
    rd(8'h14, 32'h00780073, "R3 dst1 readback");
    // R2: rejected accesses
    acc(1, 8'h20, 32'hDEADBEEF, 4'b0111, 0);
    chk("R2 partial select err", 32'(gotErr), 1);
    rd(8'h20, 32'h12345671, "R2 color unchanged");
    acc(1, 8'h21, 32'hDEADBEEF, 4'hF, 0); chk("R2 misaligned err", 32'(gotErr), 1);
    acc(0, 8'h3C, 32'h0, 4'hF, 0); chk("R2 out of window err", 32'(gotErr), 1);
    chk("R12 no data on err", gotDat, 0);
    acc(1, 8'hFC, 32'h100, 4'hF, 0); chk("R2 no start on err", 32'(gotRect), 0);
    // R4: modes
    wr(8'h00, 32'h0000001D); rd(8'h00, 32'h1D, "R4 control readback");
    // R8: done while idle
    pulseDone; chk("R8 idle done ignored", 32'(irqOut), 0);
    // R5/R6: rectangle
    wr(8'h00, 32'h00000115);
    chk("R5 rect pulse", 32'(gotRect), 1); chk("R6 busy with pulse", 32'(busyOut), 1);
    rd(8'h00, 32'h15, "R4 draw bits not stored");
    rd(8'h04, 32'h1, "R10 status busy");
    // R7: request while busy
    wr(8'h00, 32'h00000203);
    chk("R7 no pulse while busy", 32'(gotLine), 0);
    chk("R7 mode still stored", 32'(colorDepth), 3);
    pulseDone;
    chk("R8 busy cleared", 32'(busyOut), 0); chk("R8 irq set", 32'(irqOut), 1);
    rd(8'h04, 32'h2, "R10 status irq");
    wr(8'h04, 32'hFFFFFFFD); chk("R9 no clear without bit1", 32'(irqOut), 1);
    wr(8'h04, 32'h2); chk("R9 irq cleared", 32'(irqOut), 0);
    // R5: line, then both bits
    wr(8'h00, 32'h00000201); chk("R5 line pulse", 32'(gotLine), 1);
    pulseDone;
    wr(8'h00, 32'h00000300);
    chk("R5 both bits rect", 32'(gotRect), 1); chk("R5 both bits no line", 32'(gotLine), 0);
    // R9: done and clear in the same cycle
    acc(1, 8'h04, 32'h2, 4'hF, 1);
    chk("R9 done wins over clear", 32'(irqOut), 1);
    // R11: reset while busy with irq
    wr(8'h00, 32'h00000100);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    chk("R11 busy cleared", 32'(busyOut), 0);
    chk("R11 irq cleared", 32'(irqOut), 0);
    chk("R11 key cleared", keyColor, 0);
    rd(8'h20, 32'h0, "R11 color cleared");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule